// File: doc/BRIEF.md
# Vector Element Predicate Mask Generator

This block converts the 4-bit predication code of a vector instruction into a per-element enable mask. The mask covers a vector length VL from 0 to 64. The pipeline raises `start` with the code, VL and three scalar register values. The block then returns a 64-bit mask together with a one-cycle `done` pulse. If the code is reserved, it raises an illegal-instruction flag instead of producing a mask.

There are three kinds of code. The unmasked code and the integer-register codes are resolved in a single cycle. Each integer code tests bit i of one of three scalar registers, either as stored or inverted. A code with its top bit set uses a file of 4-bit condition fields. In that case the block walks the file one element per cycle through a read port. Element i uses field 6+i, and the field index wraps from 63 back to 0. The block tests one chosen flag of each field, either as stored or inverted.

Top module: `predmask_gen`

## Requirements
- R1: Code 0000 is reserved. One cycle after an accepted start, `done` and `illegal` both pulse, `mask` is all zero and no field read is issued.
- R2: Code 0001 enables every element below VL. `done` pulses one cycle after start.
- R3: Codes 0010/0011 test `reg_a`, 0100/0101 test `reg_b` and 0110/0111 test `reg_c`. The register values are taken in the start cycle. With an even code, element i is enabled when bit i is 1. With an odd code, it is enabled when bit i is 0.
- R4: All codes with code[3]=0 finish with `done` in the cycle after start and issue no field reads.
- R5: Codes with code[3]=1 use condition fields. code[2:1] selects the field bit: 00 selects bit 3 (LT), 01 selects bit 2 (GT), 10 selects bit 1 (EQ) and 11 selects bit 0 (SO). code[0]=0 enables an element when that bit is 1, and code[0]=1 enables it when the bit is 0.
- R6: In condition mode, element i reads field (6+i) mod 64, one read per cycle in consecutive cycles. `cr_rd_data` is used in the same cycle as `cr_rd_idx`. There are exactly VL reads, and `done` pulses in the cycle after the last read.
- R7: When `done` pulses, every mask bit at position VL or above is zero.
- R8: With VL 0 and a nonzero code, `done` pulses one cycle after start with a zero mask and no reads. A VL above 64 is treated as 64.
- R9: A `start` received while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `illegal`, `cr_rd_en` and `mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a mask; accepted when not busy |
| code | input | 4 | Predication code |
| vl | input | 7 | Vector length, 0 to 64 (larger values clamp) |
| reg_a | input | 64 | First scalar predicate register |
| reg_b | input | 64 | Second scalar predicate register |
| reg_c | input | 64 | Third scalar predicate register |
| busy | output | 1 | Condition-field walk in progress |
| done | output | 1 | One-cycle pulse: mask or illegal result ready |
| illegal | output | 1 | Pulses with done for the reserved code |
| mask | output | 64 | Element enable mask, held until the next start |
| cr_rd_en | output | 1 | Field read strobe |
| cr_rd_idx | output | 6 | Field number being read |
| cr_rd_data | input | 4 | Field contents, bit 3 LT down to bit 0 SO |

## Verification
The hardest case to reach is the field index wrapping past 63 while a walk is in progress. It only occurs when VL is 59 or more. The bench therefore sweeps every code over lengths of 57, 58, 59 and 64, and over a clamped length of 70. During each walk it checks every read index against (6+i) mod 64. A second case is a start that arrives while a walk is under way. The bench issues one in the cycle after a condition-mode start and confirms that the first request's mask and timing are unchanged.

// File: rtl/predmask_gen.sv
module predmask_gen #(
  parameter int MAX_VL    = 64,
  parameter int CR_FIELDS = 64,
  parameter int CR_BASE   = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [3:0]                   code,
  input  logic [$clog2(MAX_VL+1)-1:0]  vl,
  input  logic [MAX_VL-1:0]            reg_a,
  input  logic [MAX_VL-1:0]            reg_b,
  input  logic [MAX_VL-1:0]            reg_c,
  output logic                         busy,
  output logic                         done,
  output logic                         illegal,
  output logic [MAX_VL-1:0]            mask,
  output logic                         cr_rd_en,
  output logic [$clog2(CR_FIELDS)-1:0] cr_rd_idx,
  input  logic [3:0]                   cr_rd_data
);
  localparam int VLW = $clog2(MAX_VL + 1);
  localparam int EIW = $clog2(MAX_VL);
  localparam int CIW = $clog2(CR_FIELDS);
  localparam logic [VLW-1:0] VL_TOP   = VLW'(MAX_VL);
  localparam logic [CIW-1:0] IDX_LAST = CIW'(CR_FIELDS - 1);
  localparam logic [CIW-1:0] IDX_BASE = CIW'(CR_BASE);

  logic              busy_q, done_q, illegal_q;
  logic [2:0]        sel_q;
  logic [VLW-1:0]    vl_q, elem_q;
  logic [CIW-1:0]    idx_q;
  logic [MAX_VL-1:0] mask_q;

  logic              accept;
  logic [VLW-1:0]    vl_eff;
  logic [MAX_VL-1:0] lim, int_src, int_mask;
  logic              flag_bit;

  assign accept = start & ~busy_q;
  assign vl_eff = (vl > VL_TOP) ? VL_TOP : vl;

  for (genvar i = 0; i < MAX_VL; i++) begin : g_lim
    assign lim[i] = VLW'(i) < vl_eff;
  end

  always_comb begin
    case (code[2:1])
      2'b01:   int_src = reg_a;
      2'b10:   int_src = reg_b;
      2'b11:   int_src = reg_c;
      default: int_src = '0;
    endcase
  end

  assign int_mask = (int_src ^ {MAX_VL{code[0]}}) & lim;
  assign flag_bit = cr_rd_data[~sel_q[2:1]] ^ sel_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      sel_q     <= '0;
      vl_q      <= '0;
      elem_q    <= '0;
      idx_q     <= '0;
      mask_q    <= '0;
    end else begin
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
      if (accept) begin
        vl_q  <= vl_eff;
        sel_q <= code[2:0];
        if (code == 4'b0000) begin
          done_q    <= 1'b1;
          illegal_q <= 1'b1;
          mask_q    <= '0;
        end else if (!code[3] || vl_eff == '0) begin
          done_q <= 1'b1;
          mask_q <= code[3] ? '0 : int_mask;
        end else begin
          busy_q <= 1'b1;
          elem_q <= '0;
          idx_q  <= IDX_BASE;
          mask_q <= '0;
        end
      end else if (busy_q) begin
        mask_q[elem_q[EIW-1:0]] <= flag_bit;
        idx_q  <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        elem_q <= elem_q + 1'b1;
        if (elem_q == vl_q - 1'b1) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign illegal   = illegal_q;
  assign mask      = mask_q;
  assign cr_rd_en  = busy_q;
  assign cr_rd_idx = idx_q;

  assert_illegal_nomask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && mask == '0));

  assert_int_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !code[3]) |=> (done && !cr_rd_en));

  assert_first_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && code[3] && vl != '0) |=> (cr_rd_en && cr_rd_idx == IDX_BASE));

  assert_index_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_rd_en && cr_rd_idx == IDX_LAST) |=> (!cr_rd_en || cr_rd_idx == '0));

  assert_mask_below_vl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((mask >> vl_q) == '0));

  assert_zero_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vl == '0) |=> (done && !cr_rd_en && mask == '0));

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
endmodule

// File: tb/tb_predmask_gen.sv
module tb_predmask_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  code = '0;
  logic [6:0]  vl = '0;
  logic [63:0] reg_a = '0, reg_b = '0, reg_c = '0;
  logic        busy, done, illegal, cr_rd_en;
  logic [63:0] mask;
  logic [5:0]  cr_rd_idx;
  logic [3:0]  cr_rd_data;
  logic [3:0]  crf [64];

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  assign cr_rd_data = crf[cr_rd_idx];

  predmask_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code), .vl(vl),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c),
    .busy(busy), .done(done), .illegal(illegal), .mask(mask),
    .cr_rd_en(cr_rd_en), .cr_rd_idx(cr_rd_idx), .cr_rd_data(cr_rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [3:0] c, input int v,
                                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] r);
    logic [63:0] m = '0;
    for (int i = 0; i < v; i++) begin
      logic e;
      if (c == 4'b0000) e = 1'b0;
      else if (c == 4'b0001) e = 1'b1;
      else if (!c[3]) begin
        case (c[2:1])
          2'b01:   e = a[i];
          2'b10:   e = b[i];
          default: e = r[i];
        endcase
        e = e ^ c[0];
      end else begin
        logic [3:0] f = crf[(6 + i) % 64];
        e = f[3 - c[2:1]] ^ c[0];
      end
      m[i] = e;
    end
    return m;
  endfunction

  task automatic run_one(input logic [3:0] c, input logic [6:0] v, input logic [63:0] a,
                         input logic [63:0] b, input logic [63:0] r);
    int ve, cyc, reads, idxerr, exp_cyc, exp_reads;
    logic got;
    logic [63:0] gm, em;
    logic gi;
    ve = (v > 64) ? 64 : int'(v);
    em = model(c, ve, a, b, r);
    exp_reads = (c[3] && ve > 0) ? ve : 0;
    exp_cyc = exp_reads + 1;
    @(negedge clk);
    start = 1'b1; code = c; vl = v; reg_a = a; reg_b = b; reg_c = r;
    @(negedge clk);
    start = 1'b0; reg_a = ~a; reg_b = ~b; reg_c = ~r; code = ~c;
    cyc = 1; reads = 0; idxerr = 0; got = 1'b0; gm = '0; gi = 1'b0;
    while (!got && cyc < 200) begin
      if (cr_rd_en) begin
        if (int'(cr_rd_idx) != (6 + reads) % 64) idxerr++;
        reads++;
      end
      if (done) begin
        got = 1'b1; gm = mask; gi = illegal;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (c == 4'b0000)      check(gm == em && gi, "R1 reserved code", gm, em);
    else if (c == 4'b0001) check(gm == em && !gi, "R2 unmasked", gm, em);
    else if (!c[3])        check(gm == em && !gi, "R3 integer mask", gm, em);
    else                   check(gm == em && !gi, "R5 condition mask", gm, em);
    if (!c[3]) check(cyc == 1 && reads == 0, "R4 integer latency", 64'(cyc), 64'd1);
    else       check(cyc == exp_cyc, "R6 walk latency", 64'(cyc), 64'(exp_cyc));
    check(reads == exp_reads && idxerr == 0, "R6 read count and index", 64'(reads), 64'(exp_reads));
    check((gm >> ve) == '0, "R7 bits above VL", gm, em);
    if (ve == 0) check(gm == '0 && cyc == 1, "R8 zero length", gm, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [6:0] lens [8];
    lens = '{7'd0, 7'd1, 7'd5, 7'd57, 7'd58, 7'd59, 7'd64, 7'd70};
    for (int i = 0; i < 64; i++) crf[i] = 4'((i * 5 + 3) ^ (i >> 2));
    repeat (3) @(negedge clk);
    check(!busy && !done && !illegal && !cr_rd_en && mask == '0, "R10 reset state", mask, 64'd0);
    rst_n = 1'b1;

    for (int pass = 0; pass < 2; pass++) begin
      if (pass == 1) for (int i = 0; i < 64; i++) crf[i] = ~crf[i] ^ 4'(i);
      for (int c = 0; c < 16; c++) begin
        for (int l = 0; l < 8; l++) begin
          run_one(4'(c), lens[l],
                  64'hA5C3_0F96_1234_8E71 ^ (64'(c) << (l * 3)) ^ 64'(pass),
                  64'h5E0F_3C71_CAFE_0D92 + 64'(l * 977 + pass),
                  {32'(c * 131 + l), 32'hF0E1_D2C3} ^ {64{pass[0]}});
        end
      end
    end

    // R9: a second start during a condition walk must be ignored
    begin
      int cyc;
      logic [63:0] em;
      em = model(4'b1000, 10, '0, '0, '0);
      @(negedge clk);
      start = 1'b1; code = 4'b1000; vl = 7'd10;
      @(negedge clk);
      code = 4'b0001; vl = 7'd3;
      @(negedge clk);
      start = 1'b0;
      cyc = 2;
      while (!done && cyc < 200) begin
        @(negedge clk);
        cyc++;
      end
      check(mask == em, "R9 start while busy mask", mask, em);
      check(cyc == 11, "R9 start while busy latency", 64'(cyc), 64'd11);
      @(negedge clk);
      check(!done && !busy, "R9 no second result", 64'(done), 64'd0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule